// File: doc/BRIEF.md
# Byte-read capture register pair

This block keeps two snapshot registers of a free-running up-counter. A snapshot is taken when a hardware event arrives on one of two edge inputs, with the edge-to-register mapping chosen by a 2-bit trigger mode. Software can also take one with a single-cycle command strobe, which loads register 0. Each register pulses a latch strobe for one cycle when it loads, so toggle logic further along can follow the captures.

Software reads the registers over a narrow byte bus, low byte first and high byte second. A low-byte read freezes all capturing, so the high byte that follows comes from the same snapshot. The matching high-byte read releases the freeze. The freeze depends only on the read order. Stopping and restarting the timer (the `run_i` input) does not clear it. Any trigger that arrives while capturing is frozen is dropped.

Top module: `snap_capture_pair`

## Requirements
- R1: After reset both snapshot registers read 0, the latch strobes are low and capturing is not frozen.
- R2: With `mode_i`=01, a rising edge on `evt_i[0]` loads register 0 and a rising edge on `evt_i[1]` loads register 1. An edge counts in the cycle where the input is first sampled high after being low. The value loaded is `count_i` of that cycle, and it is readable from the next cycle on.
- R3: With `mode_i`=10, a rising edge on `evt_i[0]` loads register 0 and a falling edge on `evt_i[0]` loads register 1. `evt_i[1]` has no effect.
- R4: With `mode_i`=00 or 11, no edge input loads either register.
- R5: A `sw_cap_i` strobe while `run_i`=1 loads `count_i` into register 0 in every mode, and leaves register 1 alone.
- R6: A `sw_cap_i` strobe while `run_i`=0 has no effect.
- R7: `rd_data_o` shows a byte of a register at all times. `rd_addr_i[1]` selects the register and `rd_addr_i[0]` selects the byte (0 = bits 7:0, 1 = bits 15:8).
- R8: A cycle with `rd_en_i`=1 and `rd_addr_i[0]`=0 freezes capturing from that same cycle on. The freeze holds up to and including the next cycle with `rd_en_i`=1 and `rd_addr_i[0]`=1. Triggers during the freeze are dropped and are not replayed later.
- R9: The freeze stays in place while `run_i` goes to 0 and back to 1.
- R10: `latch_o[n]` is high for exactly the one cycle after register n loads, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 16 | Up-counter value to snapshot |
| run_i | input | 1 | Timer prescaler running |
| evt_i | input | 2 | Edge event inputs, synchronous to clk |
| mode_i | input | 2 | Hardware trigger mode |
| sw_cap_i | input | 1 | Software capture strobe for register 0 |
| rd_en_i | input | 1 | Byte read access strobe |
| rd_addr_i | input | 2 | Bit 1 selects the register, bit 0 selects the byte |
| rd_data_o | output | 8 | Selected byte |
| latch_o | output | 2 | One-cycle load strobe per register |

## Verification
The freeze flag can go wrong inside the block. If it is set when it should not be, a trigger in the next cycle produces no latch strobe and leaves the register unchanged. If it is cleared too early, a trigger between the two byte reads changes the register, so the high byte read next no longer matches the low byte. Trigger decode errors show up one cycle after the bad edge, either as a strobe on the wrong bit or as a byte value that differs from the counter sample.

// File: rtl/snap_cap_pkg.sv
`timescale 1ns/1ps
package snap_cap_pkg;
   localparam int unsigned NSLOT = 2;
   typedef enum logic [1:0] {
      TRIG_OFF       = 2'b00,
      TRIG_TWO_PIN   = 2'b01,
      TRIG_BOTH_EDGE = 2'b10,
      TRIG_RSVD      = 2'b11
   } trig_mode_e;
endpackage

// File: rtl/edge_sense.sv
`timescale 1ns/1ps
module edge_sense #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_i,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q;
   assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/read_lock.sv
`timescale 1ns/1ps
module read_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en_i,
   input  logic byte_hi_i,
   output logic suspend_o,
   output logic lock_o
);
   logic lock_q;

   // Only the byte order of the reads moves this flag; run state never touches it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lock_q <= 1'b0;
      else if (rd_en_i) lock_q <= ~byte_hi_i;
   end

   // The low-byte read cycle is itself frozen, so the sample cannot change under it.
   assign suspend_o = lock_q | (rd_en_i & ~byte_hi_i);
   assign lock_o    = lock_q;
endmodule

// File: rtl/cap_slot.sv
`timescale 1ns/1ps
module cap_slot #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take_i,
   input  logic [W-1:0] value_i,
   output logic [W-1:0] value_o,
   output logic         pulse_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_o <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= take_i;
         if (take_i) value_o <= value_i;
      end
   end
endmodule

// File: rtl/snap_capture_pair.sv
`timescale 1ns/1ps
module snap_capture_pair
   import snap_cap_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 8,
   parameter bit          SW_GATE_RUN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W-1:0]         count_i,
   input  logic                     run_i,
   input  logic [1:0]               evt_i,
   input  logic [1:0]               mode_i,
   input  logic                     sw_cap_i,
   input  logic                     rd_en_i,
   input  logic [1:0]               rd_addr_i,
   output logic [BUS_W-1:0]         rd_data_o,
   output logic [NSLOT-1:0]         latch_o
);
   localparam int unsigned NBYTE = CNT_W / BUS_W;

   if (NBYTE != 2 || CNT_W != NBYTE * BUS_W) begin : g_bad_width
      $error("snap_capture_pair: CNT_W must be exactly two bus bytes");
   end

   logic [1:0]                   rise, fall;
   logic                         suspend, lock_q, sw_ok;
   logic [NSLOT-1:0]             trig, take;
   logic [NSLOT-1:0][CNT_W-1:0]  cap_val;

   edge_sense #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(evt_i), .rise_o(rise), .fall_o(fall)
   );

   read_lock u_lock (
      .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .byte_hi_i(rd_addr_i[0]),
      .suspend_o(suspend), .lock_o(lock_q)
   );

   if (SW_GATE_RUN) begin : g_sw_gated
      assign sw_ok = sw_cap_i & run_i;
   end else begin : g_sw_free
      assign sw_ok = sw_cap_i;
   end

   always_comb begin
      trig = '0;
      unique case (trig_mode_e'(mode_i))
         TRIG_TWO_PIN:   trig = {rise[1], rise[0]};
         TRIG_BOTH_EDGE: trig = {fall[0], rise[0]};
         default:        trig = '0;
      endcase
      trig[0] = trig[0] | sw_ok;
   end

   assign take = suspend ? '0 : trig;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      cap_slot #(.W(CNT_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .take_i(take[s]), .value_i(count_i),
         .value_o(cap_val[s]), .pulse_o(latch_o[s])
      );
   end

   assign rd_data_o = cap_val[rd_addr_i[1]][rd_addr_i[0]*BUS_W +: BUS_W];
endmodule

// File: rtl/snap_capture_chk.sv
`timescale 1ns/1ps
module snap_capture_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_i,
   input logic             run_i,
   input logic [1:0]       mode_i,
   input logic             sw_cap_i,
   input logic             rd_en_i,
   input logic [1:0]       rd_addr_i,
   input logic [1:0]       latch_o,
   input logic [CNT_W-1:0] cap0,
   input logic [CNT_W-1:0] cap1,
   input logic             lock_q
);
   // R2
   cap0_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o[0] |-> cap0 == $past(count_i));
   // R2
   cap1_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o[1] |-> cap1 == $past(count_i));
   // R8
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(cap0) && $stable(cap1) && latch_o == 2'b00));
   // R9
   lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !(rd_en_i && rd_addr_i[0])) |=> lock_q);
   // R4
   no_hw_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 || mode_i == 2'b11) |=> !latch_o[1]);
   // R6
   sw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 && !run_i) |=> !latch_o[0]);
   // R5
   sw_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_cap_i && run_i && !lock_q && !(rd_en_i && !rd_addr_i[0])) |=> latch_o[0]);
endmodule

bind snap_capture_pair snap_capture_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .count_i(count_i), .run_i(run_i), .mode_i(mode_i),
   .sw_cap_i(sw_cap_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
   .latch_o(latch_o), .cap0(cap_val[0]), .cap1(cap_val[1]), .lock_q(lock_q)
);

// File: tb/tb_snap_capture_pair.sv
`timescale 1ns/10ps
module tb_snap_capture_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt = 16'h1234;
   logic        run = 1'b1;
   logic [1:0]  evt = 2'b00;
   logic [1:0]  mode = 2'b00;
   logic        sw_cap = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_addr = 2'b00;
   logic [7:0]  rd_data;
   logic [1:0]  latch;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   logic [15:0] exp_cap [2];
   logic        exp_lock = 1'b0;
   logic [1:0]  prev_evt = 2'b00;

   always #2.5 clk = ~clk;

   snap_capture_pair dut (
      .clk(clk), .rst_n(rst_n), .count_i(cnt), .run_i(run), .evt_i(evt),
      .mode_i(mode), .sw_cap_i(sw_cap), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .latch_o(latch)
   );

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic peek(string tag);
      for (int a = 0; a < 4; a++) begin
         rd_addr = a[1:0];
         #0.2;
         chk(tag, {8'h00, rd_data}, {8'h00, a[0] ? exp_cap[a/2][15:8] : exp_cap[a/2][7:0]});
      end
   endtask

   task automatic tick(string tag);
      logic [1:0] rise, fall, t;
      logic       susp;
      susp = exp_lock | (rd_en & ~rd_addr[0]);
      rise = evt & ~prev_evt;
      fall = ~evt & prev_evt;
      t[0] = ((mode == 2'b01 || mode == 2'b10) && rise[0]) || (sw_cap && run);
      t[1] = (mode == 2'b01) ? rise[1] : (mode == 2'b10) ? fall[0] : 1'b0;
      if (susp) t = 2'b00;
      if (t[0]) exp_cap[0] = cnt;
      if (t[1]) exp_cap[1] = cnt;
      if (rd_en) exp_lock = ~rd_addr[0];
      prev_evt = evt;
      @(posedge clk);
      @(negedge clk);
      // R10: strobe in the cycle after the load
      chk("R10", {14'd0, latch}, {14'd0, t});
      sw_cap = 1'b0;
      rd_en  = 1'b0;
      if (run) cnt = cnt + 16'h0137;
      peek(tag);
   endtask

   task automatic rd_byte(logic [1:0] addr, string tag);
      rd_en = 1'b1;
      rd_addr = addr;
      #0.2;
      // R7: byte map
      chk(tag, {8'h00, rd_data}, {8'h00, addr[0] ? exp_cap[addr[1]][15:8] : exp_cap[addr[1]][7:0]});
   endtask

   initial begin
      exp_cap[0] = '0;
      exp_cap[1] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {14'd0, latch}, 16'd0);
      peek("R1");
      rst_n = 1'b1;
      tick("R1");

      // R2 R3 R4: every previous/current edge pattern in every mode
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 16; p++) begin
            mode = m[1:0];
            evt = p[1:0];
            tick(m == 1 ? "R2" : m == 2 ? "R3" : "R4");
            evt = p[3:2];
            tick(m == 1 ? "R2" : m == 2 ? "R3" : "R4");
         end
      end

      // R5 R6: software strobe with and without run
      evt = 2'b00;
      tick("R5");
      for (int r = 0; r < 2; r++) begin
         for (int m = 0; m < 4; m++) begin
            run = r[0];
            mode = m[1:0];
            sw_cap = 1'b1;
            tick(r == 1 ? "R5" : "R6");
         end
      end
      run = 1'b1;

      // R8: low read freezes, including a trigger in the same cycle
      mode = 2'b01;
      evt = 2'b00;
      tick("R8");
      evt = 2'b11;
      tick("R8");
      evt = 2'b00;
      tick("R8");
      rd_byte(2'b00, "R7");
      evt = 2'b11;
      tick("R8");
      evt = 2'b00;
      tick("R8");
      evt = 2'b11;
      sw_cap = 1'b1;
      tick("R8");
      // R9: stop and restart the timer while frozen
      run = 1'b0;
      evt = 2'b00;
      tick("R9");
      tick("R9");
      run = 1'b1;
      evt = 2'b11;
      sw_cap = 1'b1;
      tick("R9");
      evt = 2'b00;
      tick("R9");
      // high read releases, trigger in that cycle still dropped
      rd_byte(2'b01, "R7");
      evt = 2'b11;
      tick("R8");
      evt = 2'b00;
      tick("R8");
      evt = 2'b11;
      tick("R8");
      // freeze through register 1 reads
      evt = 2'b00;
      rd_byte(2'b10, "R7");
      tick("R8");
      evt = 2'b10;
      tick("R8");
      rd_byte(2'b11, "R7");
      tick("R8");
      evt = 2'b00;
      tick("R8");
      evt = 2'b10;
      tick("R8");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule